// File: doc/BRIEF.md
# JESD204B Transmit Link Sequencer

This block drives the octet stream of one JESD204B transmit lane at the link layer. It starts in code group synchronisation and sends comma characters for as long as the receiver requests synchronisation. When the request is released it waits for a local multiframe clock (LMFC) boundary. It then sends the four-multiframe initial lane alignment sequence and hands the lane over to transport-layer payload octets. The LMFC is an octet counter and a frame counter that wrap at the programmed frame size F and multiframe length K. SYSREF realigns them. 8b/10b encoding, scrambling and serialisation take place downstream.

The payload input is a valid/ready stream. `in_ready` is high in exactly the cycles of the data phase, and it does not depend on `in_valid`. An octet is consumed when both are high. If `in_valid` is low in a data-phase cycle, a 0x00 filler octet goes out and nothing is consumed. The lane output has no back-pressure: one octet and its control flag leave on every cycle. The output follows the current state, counters and payload input combinationally.

Top module: `jtx_link_seq`

## Requirements
- R1: After reset, and in every cycle of synchronisation with the test bit clear, the lane sends 0xBC with the control flag set, and `in_ready` is low.
- R2: With `sync_sel` = 0 the request is `sync_ext`, and with `sync_sel` = 1 it is `sync_reg`. The unselected input has no effect.
- R3: Alignment begins at the (`ila_hold`+1)-th multiframe boundary (frame 0, octet 0) whose octet follows the clock edge that first samples the request released. Commas continue until then.
- R4: Alignment lasts four multiframes of K frames of F octets. Index 0 of each multiframe is 0x1C (control) and the last index is 0x7C (control). Other indices carry the low eight bits of the index, where index = frame·F + octet, as data.
- R5: In the second alignment multiframe, index 1 is 0x9C (control) and indices 2 to NCFG+1 carry the configuration octets as data. Octet j is taken from `cfg_octets[8j+7:8j]`. The end marker takes precedence.
- R6: The octet after the last alignment octet starts the data phase. There `out_data` is `in_data` when `in_valid` is high and 0x00 otherwise, `out_k` is 0 and `in_ready` is 1.
- R7: With `ila_skip` set, the data phase starts at the boundary where alignment would have started.
- R8: On SYSREF, the next cycle is octet 0 of frame 0. When `lmfc_force` is set, it is octet 0 of frame `lmfc_start` instead.
- R9: With `sync_test` set, the synchronisation octets alternate between 0xBC (control) and 0x50 (data). 0xBC is sent in the first cycle after reset or after entering synchronisation.
- R10: A request raised during alignment or data returns the lane to commas at the next frame start (octet 0). This takes precedence over the alignment-to-data handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_ext | input | 1 | Synchronisation request from the receiver pin, active high |
| sync_reg | input | 1 | Synchronisation request from a control bit |
| sync_sel | input | 1 | Selects `sync_reg` (1) or `sync_ext` (0) |
| sysref | input | 1 | LMFC realignment pulse |
| lmfc_force | input | 1 | Reload the frame counter with `lmfc_start` on SYSREF |
| lmfc_start | input | K_M1_W | Frame counter reload value, at most K-1 |
| f_m1 | input | F_M1_W | Octets per frame minus one |
| k_m1 | input | K_M1_W | Frames per multiframe minus one |
| ila_hold | input | 2 | Extra multiframes before alignment starts |
| ila_skip | input | 1 | Skip alignment and go straight to data |
| sync_test | input | 1 | Alternate-word synchronisation test mode |
| cfg_octets | input | NCFG*8 | Link configuration octets |
| in_data | input | 8 | Payload octet |
| in_valid | input | 1 | Payload octet valid |
| in_ready | output | 1 | Payload accepted (data phase) |
| out_data | output | 8 | Lane octet |
| out_k | output | 1 | Lane octet is a control character |

## Verification
The case that needs care is a re-synchronisation request that arrives on the edge where the fourth alignment multiframe ends. That edge is also a frame start, so the return to commas and the handover to payload both want the same next cycle. The bench raises the request while the last 0x7C marker is on the lane. It expects a comma in the following cycle with `in_ready` still low. A request raised in the middle of a data frame is also checked: payload must continue until the frame ends.

// File: rtl/jtx_pkg.sv
package jtx_pkg;
  typedef enum logic [1:0] {
    ST_SYNC = 2'd0,
    ST_WAIT = 2'd1,
    ST_ILA  = 2'd2,
    ST_DATA = 2'd3
  } seq_st_e;

  localparam logic [7:0] K_COMMA    = 8'hBC;
  localparam logic [7:0] K_MF_START = 8'h1C;
  localparam logic [7:0] K_MF_END   = 8'h7C;
  localparam logic [7:0] K_CFG_MARK = 8'h9C;
  localparam logic [7:0] D_TEST_ALT = 8'h50;
endpackage

// File: rtl/jtx_lmfc.sv
module jtx_lmfc #(
  parameter int F_M1_W = 3,
  parameter int K_M1_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sysref,
  input  logic              force_start,
  input  logic [K_M1_W-1:0] start_frm,
  input  logic [F_M1_W-1:0] f_m1,
  input  logic [K_M1_W-1:0] k_m1,
  output logic [F_M1_W-1:0] oct_cnt,
  output logic [K_M1_W-1:0] frm_cnt,
  output logic              bnd_nxt,
  output logic              fstart_nxt
);
  logic [F_M1_W-1:0] oct_n;
  logic [K_M1_W-1:0] frm_n;

  // next position of the multiframe clock
  always_comb begin
    oct_n = oct_cnt;
    frm_n = frm_cnt;
    if (sysref) begin
      oct_n = '0;
      frm_n = force_start ? start_frm : '0;
    end else if (oct_cnt >= f_m1) begin
      oct_n = '0;
      frm_n = (frm_cnt >= k_m1) ? '0 : frm_cnt + 1'b1;
    end else begin
      oct_n = oct_cnt + 1'b1;
    end
  end

  assign fstart_nxt = (oct_n == '0);
  assign bnd_nxt    = (oct_n == '0) && (frm_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oct_cnt <= '0;
      frm_cnt <= '0;
    end else begin
      oct_cnt <= oct_n;
      frm_cnt <= frm_n;
    end
  end
endmodule

// File: rtl/jtx_seq_ctrl.sv
module jtx_seq_ctrl
  import jtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       bnd_nxt,
  input  logic       fstart_nxt,
  input  logic [1:0] hold_cfg,
  input  logic       skip_ila,
  output logic       in_cgs,
  output logic       in_ila,
  output logic       in_data,
  output logic [1:0] mf_idx,
  output logic       tog
);
  seq_st_e    st_q, st_d;
  logic [1:0] hold_q, hold_d;
  logic [1:0] mf_q, mf_d;
  logic       tog_d;
  logic       cgs_d;

  assign in_cgs  = (st_q == ST_SYNC) || (st_q == ST_WAIT);
  assign in_ila  = (st_q == ST_ILA);
  assign in_data = (st_q == ST_DATA);
  assign mf_idx  = mf_q;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    mf_d   = mf_q;
    unique case (st_q)
      ST_SYNC: begin
        if (!req) begin
          if (bnd_nxt && (hold_cfg == 2'd0)) begin
            st_d = skip_ila ? ST_DATA : ST_ILA;
            mf_d = 2'd0;
          end else begin
            st_d   = ST_WAIT;
            hold_d = bnd_nxt ? hold_cfg - 2'd1 : hold_cfg;
          end
        end
      end
      ST_WAIT: begin
        if (req) begin
          st_d = ST_SYNC;
        end else if (bnd_nxt) begin
          if (hold_q == 2'd0) begin
            st_d = skip_ila ? ST_DATA : ST_ILA;
            mf_d = 2'd0;
          end else begin
            hold_d = hold_q - 2'd1;
          end
        end
      end
      ST_ILA: begin
        if (req && fstart_nxt) begin
          st_d = ST_SYNC;
        end else if (bnd_nxt) begin
          if (mf_q == 2'd3) st_d = ST_DATA;
          else              mf_d = mf_q + 2'd1;
        end
      end
      ST_DATA: begin
        if (req && fstart_nxt) st_d = ST_SYNC;
      end
      default: st_d = ST_SYNC;
    endcase
    cgs_d = (st_d == ST_SYNC) || (st_d == ST_WAIT);
    tog_d = (cgs_d && in_cgs) ? ~tog : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SYNC;
      hold_q <= 2'd0;
      mf_q   <= 2'd0;
      tog    <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
      mf_q   <= mf_d;
      tog    <= tog_d;
    end
  end
endmodule

// File: rtl/jtx_ila_gen.sv
module jtx_ila_gen
  import jtx_pkg::*;
#(
  parameter int F_M1_W = 3,
  parameter int K_M1_W = 5,
  parameter int NCFG   = 14
) (
  input  logic [F_M1_W-1:0] f_m1,
  input  logic [K_M1_W-1:0] k_m1,
  input  logic [F_M1_W-1:0] oct_cnt,
  input  logic [K_M1_W-1:0] frm_cnt,
  input  logic [1:0]        mf_idx,
  input  logic [NCFG*8-1:0] cfg_octets,
  output logic [7:0]        ila_oct,
  output logic              ila_k
);
  localparam int IDX_W = F_M1_W + K_M1_W;

  logic [IDX_W-1:0] idx;
  logic             is_last;
  logic             cfg_hit;
  logic [7:0]       cfg_val;

  assign idx     = IDX_W'(frm_cnt) * (IDX_W'(f_m1) + IDX_W'(1)) + IDX_W'(oct_cnt);
  assign is_last = (frm_cnt == k_m1) && (oct_cnt == f_m1);

  always_comb begin
    cfg_hit = 1'b0;
    cfg_val = 8'h00;
    for (int j = 0; j < NCFG; j++) begin
      if (idx == IDX_W'(j + 2)) begin
        cfg_hit = 1'b1;
        cfg_val = cfg_octets[j*8 +: 8];
      end
    end
  end

  // priority: start marker, end marker, config marker, config octets, filler
  always_comb begin
    ila_oct = 8'(idx);
    ila_k   = 1'b0;
    if (idx == '0) begin
      ila_oct = K_MF_START;
      ila_k   = 1'b1;
    end else if (is_last) begin
      ila_oct = K_MF_END;
      ila_k   = 1'b1;
    end else if (mf_idx == 2'd1 && idx == IDX_W'(1)) begin
      ila_oct = K_CFG_MARK;
      ila_k   = 1'b1;
    end else if (mf_idx == 2'd1 && cfg_hit) begin
      ila_oct = cfg_val;
    end
  end
endmodule

// File: rtl/jtx_link_seq.sv
module jtx_link_seq
  import jtx_pkg::*;
#(
  parameter int F_M1_W = 3,
  parameter int K_M1_W = 5,
  parameter int NCFG   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_ext,
  input  logic              sync_reg,
  input  logic              sync_sel,
  input  logic              sysref,
  input  logic              lmfc_force,
  input  logic [K_M1_W-1:0] lmfc_start,
  input  logic [F_M1_W-1:0] f_m1,
  input  logic [K_M1_W-1:0] k_m1,
  input  logic [1:0]        ila_hold,
  input  logic              ila_skip,
  input  logic              sync_test,
  input  logic [NCFG*8-1:0] cfg_octets,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [7:0]        out_data,
  output logic              out_k
);
  logic              req;
  logic [F_M1_W-1:0] oct_cnt;
  logic [K_M1_W-1:0] frm_cnt;
  logic              bnd_nxt, fstart_nxt;
  logic              st_cgs, st_ila, st_data, tog;
  logic [1:0]        mf_idx;
  logic [7:0]        ila_oct;
  logic              ila_k;

  assign req = sync_sel ? sync_reg : sync_ext;

  jtx_lmfc #(.F_M1_W(F_M1_W), .K_M1_W(K_M1_W)) u_lmfc (
    .clk(clk), .rst_n(rst_n), .sysref(sysref), .force_start(lmfc_force),
    .start_frm(lmfc_start), .f_m1(f_m1), .k_m1(k_m1),
    .oct_cnt(oct_cnt), .frm_cnt(frm_cnt), .bnd_nxt(bnd_nxt), .fstart_nxt(fstart_nxt)
  );

  jtx_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .bnd_nxt(bnd_nxt), .fstart_nxt(fstart_nxt),
    .hold_cfg(ila_hold), .skip_ila(ila_skip),
    .in_cgs(st_cgs), .in_ila(st_ila), .in_data(st_data), .mf_idx(mf_idx), .tog(tog)
  );

  jtx_ila_gen #(.F_M1_W(F_M1_W), .K_M1_W(K_M1_W), .NCFG(NCFG)) u_ila (
    .f_m1(f_m1), .k_m1(k_m1), .oct_cnt(oct_cnt), .frm_cnt(frm_cnt),
    .mf_idx(mf_idx), .cfg_octets(cfg_octets), .ila_oct(ila_oct), .ila_k(ila_k)
  );

  assign in_ready = st_data;

  always_comb begin
    out_data = K_COMMA;
    out_k    = 1'b1;
    if (st_ila) begin
      out_data = ila_oct;
      out_k    = ila_k;
    end else if (st_data) begin
      out_data = in_valid ? in_data : 8'h00;
      out_k    = 1'b0;
    end else if (st_cgs && sync_test && tog) begin
      out_data = D_TEST_ALT;
      out_k    = 1'b0;
    end
  end
endmodule

// File: rtl/jtx_link_seq_chk.sv
module jtx_link_seq_chk #(
  parameter int F_M1_W = 3,
  parameter int K_M1_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              sysref,
  input logic              lmfc_force,
  input logic              st_cgs,
  input logic              st_ila,
  input logic              in_ready,
  input logic [7:0]        out_data,
  input logic              out_k,
  input logic [F_M1_W-1:0] oct_cnt,
  input logic [K_M1_W-1:0] frm_cnt
);
  p_comma_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_cgs && req) |=> st_cgs);

  p_ila_marker_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ila) |-> (out_data == 8'h1C && out_k && oct_cnt == '0 && frm_cnt == '0));

  p_data_not_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_k);

  p_data_on_bnd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (oct_cnt == '0 && frm_cnt == '0));

  p_sysref_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sysref) && !$past(lmfc_force)) |-> (oct_cnt == '0 && frm_cnt == '0));

  p_resync_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> (oct_cnt == '0));
endmodule

bind jtx_link_seq jtx_link_seq_chk #(.F_M1_W(F_M1_W), .K_M1_W(K_M1_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .sysref(sysref), .lmfc_force(lmfc_force),
  .st_cgs(st_cgs), .st_ila(st_ila), .in_ready(in_ready), .out_data(out_data),
  .out_k(out_k), .oct_cnt(oct_cnt), .frm_cnt(frm_cnt)
);

// File: tb/jtx_link_seq_tb.sv
`timescale 1ns/1ps
module jtx_link_seq_tb_top;
  localparam int F_M1_W = 3;
  localparam int K_M1_W = 5;
  localparam int NCFG   = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sync_ext = 1'b1, sync_reg = 1'b0, sync_sel = 1'b0;
  logic              sysref = 1'b0, lmfc_force = 1'b0;
  logic [K_M1_W-1:0] lmfc_start = '0;
  logic [F_M1_W-1:0] f_m1 = '0;
  logic [K_M1_W-1:0] k_m1 = '0;
  logic [1:0]        ila_hold = '0;
  logic              ila_skip = 1'b0, sync_test = 1'b0;
  logic [NCFG*8-1:0] cfg_octets;
  logic [7:0]        in_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready, out_k;
  logic [7:0]        out_data;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  jtx_link_seq #(.F_M1_W(F_M1_W), .K_M1_W(K_M1_W), .NCFG(NCFG)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_ext(sync_ext), .sync_reg(sync_reg), .sync_sel(sync_sel),
    .sysref(sysref), .lmfc_force(lmfc_force), .lmfc_start(lmfc_start), .f_m1(f_m1),
    .k_m1(k_m1), .ila_hold(ila_hold), .ila_skip(ila_skip), .sync_test(sync_test),
    .cfg_octets(cfg_octets), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_k(out_k)
  );

  function automatic logic [7:0] cfg_byte(int j);
    return 8'(8'hA0 + j * 3);
  endfunction

  task automatic chk(input logic [9:0] got, input logic [9:0] exp, input string r);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got data/k/ready %h expected %h", r, got, exp);
    end
  endtask

  task automatic drive_req(input bit sel, input bit rq);
    if (sel) begin sync_reg = rq; sync_ext = ~rq; end
    else     begin sync_ext = rq; sync_reg = ~rq; end
  endtask

  // reference sequence engine: bst 0 = sync, 1 = alignment, 2 = data
  task automatic play(input int f, input int k, input int dly, input bit skip,
                      input bit tst, input bit sel, input bit frc, input int st,
                      input int rel, input int total, input int rs, input bit rs_end);
    int p, L, seen, m, bst, old;
    bit tog, rq, vld_cur;
    logic [7:0] din_cur, ed;
    logic ek;
    string rn;
    L = f * k;
    @(negedge clk);
    rst_n = 1'b0;
    f_m1 = F_M1_W'(f - 1); k_m1 = K_M1_W'(k - 1);
    ila_hold = 2'(dly); ila_skip = skip; sync_test = tst; sync_sel = sel;
    lmfc_force = frc; lmfc_start = K_M1_W'(st);
    in_data = 8'h00; in_valid = 1'b0; din_cur = 8'h00; vld_cur = 1'b0;
    rq = 1'b1; drive_req(sel, rq);
    @(negedge clk);
    rst_n = 1'b1; sysref = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sysref = 1'b0;
    p = (st * f) % L; bst = 0; seen = 0; m = 0; tog = 1'b1;
    for (int cyc = 0; cyc < total; cyc++) begin
      if (bst == 0) begin
        if (tst && tog) begin ed = 8'h50; ek = 1'b0; end
        else begin ed = 8'hBC; ek = 1'b1; end
        rn = tst ? "R9" : (seen > 0 ? "R3" : (sel ? "R2" : "R1"));
      end else if (bst == 1) begin
        rn = "R4";
        if (p == 0) begin ed = 8'h1C; ek = 1'b1; end
        else if (p == L - 1) begin ed = 8'h7C; ek = 1'b1; end
        else if (m == 1 && p == 1) begin ed = 8'h9C; ek = 1'b1; rn = "R5"; end
        else if (m == 1 && p >= 2 && p < 2 + NCFG) begin
          ed = cfg_byte(p - 2); ek = 1'b0; rn = "R5";
        end else begin ed = 8'(p); ek = 1'b0; end
        if (frc) rn = "R8";
      end else begin
        ed = vld_cur ? din_cur : 8'h00; ek = 1'b0;
        rn = rs >= 0 ? "R10" : (skip ? "R7" : "R6");
      end
      chk({out_data, out_k, in_ready}, {ed, ek, (bst == 2)}, rn);
      if (cyc == rel) rq = 1'b0;
      if (cyc == rs) rq = 1'b1;
      if (rs_end && bst == 1 && m == 3 && p == L - 1) rq = 1'b1;
      drive_req(sel, rq);
      din_cur = 8'(cyc * 37 + 11); vld_cur = (cyc % 5) != 3;
      in_data = din_cur; in_valid = vld_cur;
      @(posedge clk);
      old = bst;
      p = (p + 1) % L;
      case (bst)
        0: if (rq) seen = 0;
           else if (p == 0) begin
             seen++;
             if (seen == dly + 1) begin bst = skip ? 2 : 1; m = 0; end
           end
        1: if (rq && (p % f) == 0) bst = 0;
           else if (p == 0) begin if (m == 3) bst = 2; else m++; end
        default: if (rq && (p % f) == 0) bst = 0;
      endcase
      if (bst == 0 && old != 0) seen = 0;
      tog = (bst == 0 && old == 0) ? ~tog : 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({out_data, out_k, in_ready}, {8'hBC, 1'b1, 1'b0}, "R1 reset");
  endtask

  // R3 R4 R5 R6: basic alignment with F=2, K=16
  task automatic t_basic();    play(2, 16, 0, 0, 0, 0, 0, 0, 5, 190, -1, 0); endtask
  // R3: three extra multiframes of hold-off, F=1, K=20
  task automatic t_hold();     play(1, 20, 3, 0, 0, 0, 0, 0, 4, 200, -1, 0); endtask
  // R7: skip alignment with one multiframe of hold-off
  task automatic t_skip();     play(4, 4, 1, 1, 0, 0, 0, 0, 2, 60, -1, 0); endtask
  // R8: forced frame start value on SYSREF
  task automatic t_force();    play(2, 8, 0, 0, 0, 0, 1, 5, 3, 100, -1, 0); endtask
  // R9: alternate synchronisation word
  task automatic t_testword(); play(1, 4, 0, 0, 1, 0, 0, 0, 9, 40, -1, 0); endtask
  // R2: request from the control bit, pin driven opposite
  task automatic t_regsrc();   play(2, 4, 0, 0, 0, 1, 0, 0, 6, 60, -1, 0); endtask
  // R10: request in the middle of a data frame
  task automatic t_resync();   play(4, 4, 0, 0, 0, 0, 0, 0, 3, 115, 93, 0); endtask
  // R10: request on the alignment-to-data handover edge
  task automatic t_collide();  play(2, 4, 0, 0, 0, 0, 0, 0, 2, 60, -1, 1); endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    for (int j = 0; j < NCFG; j++) cfg_octets[j*8 +: 8] = cfg_byte(j);
    t_reset();
    t_basic();
    t_hold();
    t_skip();
    t_force();
    t_testword();
    t_regsrc();
    t_resync();
    t_collide();
    summary();
  end

  initial begin
    #750000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule